// File: doc/BRIEF.md
# Column Command Spacing Scheduler

This block paces column command packets in a packet-based DRAM controller. A pending column command (operation code plus target device) is offered on a valid/ready handshake. The scheduler holds `cmd_ready` low until the minimum spacing for that command has elapsed since the previous column packet. The spacing depends on three commands: the pending one and the two most recently issued ones. It also depends on a per-device record of writes still waiting in a device's write buffer.

In the hazardous write-then-read patterns, the last write must be retired before the read may go out. In those cases the block fills the gap with a no-operation column packet, which it signals on `idle_ins`. All four timing values are programmable cycle counts taken from plain inputs. These inputs are expected to stay constant while commands are in flight.

Back-pressure rules: `cmd_ready` is a function of internal state and of the offered payload only; it never looks at `cmd_valid`. The requester keeps `cmd_op` and `cmd_dev` stable while `cmd_valid` is high and `cmd_ready` is low, and does not withdraw the command. A command is taken in the cycle where both signals are high, and `issue` marks that cycle.

Top module: `col_spacing_sched`

## Requirements
- R1: Any two column packets, issued or inserted, are at least `t_cc` cycles apart (issue cycle difference).
- R2: A write that follows a read, to any device, issues `t_cc + t_cac - t_cwd` cycles after the read, or `t_cc` cycles after it when `t_cac <= t_cwd`.
- R3: Read after read, write after write, a no-op after a read or write, and any command after a no-op issue exactly `t_cc` cycles after the preceding packet when offered early enough.
- R4: Write, write, read, with the oldest write and the read on the same device as the middle write: one `idle_ins` pulse comes `t_cc` cycles after the middle write. The read issues at the later of `t_rtr` cycles after the middle write and `t_cc` cycles after the pulse.
- R5: Write, write, read where the oldest write or the read names another device than the middle write: the read issues `t_cc` after the middle write, with no `idle_ins`.
- R6: Read, write, read on one device: the R4 timing applies when a write to that device was unretired at the moment the first read issued. Otherwise the read issues `t_cc` after the write.
- R7: `cmd_op` encoding: 0 no-op, 1 read, 2 write, 3 precharge-only (acts as no-op), 5 read with auto-precharge (acts as read), 6 write with auto-precharge (acts as write). Codes 4 and 7 act as no-op.
- R8: After reset the history holds two no-ops and no write is unretired. `cmd_ready` is high in the first cycle after reset.
- R9: A device's unretired-write mark is set by a write issued to it. It is cleared by a non-write command issued to it or by any `idle_ins` pulse.
- R10: `issue` is high exactly when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` follows the spacing rules above on every cycle, whatever `cmd_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_cc | input | TW | Base column-to-column spacing, cycles (at least 1) |
| t_cac | input | TW | Read-to-data latency, cycles |
| t_cwd | input | TW | Write-to-data latency, cycles |
| t_rtr | input | TW | Write-retire-to-read spacing, cycles |
| cmd_valid | input | 1 | Pending column command offered |
| cmd_ready | output | 1 | Pending command may issue this cycle |
| cmd_op | input | 3 | Operation code (see R7) |
| cmd_dev | input | DEV_W | Target device |
| issue | output | 1 | Column command packet issued this cycle |
| idle_ins | output | 1 | Inserted no-op column packet this cycle |

## Verification
The hardest case to reach is the read-write-read pattern that needs the retire gap. It depends on a write being unretired at the moment an earlier read went out, and nothing at the ports shows that state directly. The stimulus first clears the history with no-ops to an unrelated device. It then issues a write and a read to the target device, so the read captures the unretired mark. A write and a read to the same device follow. The same pattern without the leading write gives the plain-spacing counterpart.

// File: rtl/colsp_pkg.sv
package colsp_pkg;

  typedef enum logic [1:0] {
    CLS_NOP = 2'd0,
    CLS_RD  = 2'd1,
    CLS_WR  = 2'd2
  } cls_e;

  // Fold the operation code onto the spacing class it behaves like.
  function automatic cls_e colsp_classify(input logic [2:0] op);
    case (op)
      3'd1, 3'd5: return CLS_RD;
      3'd2, 3'd6: return CLS_WR;
      default:    return CLS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/colsp_hist.sv
module colsp_hist
  import colsp_pkg::*;
#(
  parameter int DEV_W = 2,
  localparam int NDEV = 1 << DEV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  cls_e             push_cls,
  input  logic [DEV_W-1:0] push_dev,
  input  logic             retire_all,
  output cls_e             a_cls,
  output logic [DEV_W-1:0] a_dev,
  output logic             a_dirty,
  output cls_e             b_cls,
  output logic [DEV_W-1:0] b_dev,
  output logic [NDEV-1:0]  dirty_vec
);

  logic b_dirty;

  // Two-deep history: b is the newest issued command, a the one before.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cls   <= CLS_NOP;
      a_dev   <= '0;
      a_dirty <= 1'b0;
      b_cls   <= CLS_NOP;
      b_dev   <= '0;
      b_dirty <= 1'b0;
    end else if (push) begin
      a_cls   <= b_cls;
      a_dev   <= b_dev;
      a_dirty <= b_dirty;
      b_cls   <= push_cls;
      b_dev   <= push_dev;
      b_dirty <= dirty_vec[push_dev];
    end
  end

  // One unretired-write mark per device.
  for (genvar d = 0; d < NDEV; d++) begin : g_wbuf
    always_ff @(posedge clk) begin
      if (!rst_n)
        dirty_vec[d] <= 1'b0;
      else if (retire_all)
        dirty_vec[d] <= 1'b0;
      else if (push && push_dev == DEV_W'(d))
        dirty_vec[d] <= (push_cls == CLS_WR);
    end
  end

endmodule

// File: rtl/colsp_rule.sv
module colsp_rule
  import colsp_pkg::*;
#(
  parameter int DEV_W = 2,
  parameter int TW    = 6,
  localparam int EW   = TW + 2
) (
  input  cls_e             c_cls,
  input  logic [DEV_W-1:0] c_dev,
  input  cls_e             a_cls,
  input  logic [DEV_W-1:0] a_dev,
  input  logic             a_dirty,
  input  cls_e             b_cls,
  input  logic [DEV_W-1:0] b_dev,
  input  logic [TW-1:0]    t_cc,
  input  logic [TW-1:0]    t_cac,
  input  logic [TW-1:0]    t_cwd,
  output logic             hazard,
  output logic [EW-1:0]    need
);

  logic same_bc, same_ab, a_blocks;

  always_comb begin
    same_bc  = (b_dev == c_dev);
    same_ab  = (a_dev == b_dev);
    // Oldest command leaves the middle write unretired.
    a_blocks = (a_cls == CLS_WR) || (a_cls == CLS_RD && a_dirty);
    hazard   = (c_cls == CLS_RD) && (b_cls == CLS_WR) && same_bc && same_ab && a_blocks;

    need = EW'(t_cc);
    if (b_cls == CLS_RD && c_cls == CLS_WR && t_cac > t_cwd)
      need = EW'(t_cc) + EW'(t_cac - t_cwd);
  end

endmodule

// File: rtl/colsp_pace.sv
module colsp_pace #(
  parameter int TW  = 6,
  localparam int EW = TW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          idle_ins,
  output logic [EW-1:0] elapsed,
  output logic [EW-1:0] since_nop,
  output logic          nop_done
);

  localparam logic [EW-1:0] SAT = '1;

  // Cycles since the last issued command, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n)               elapsed <= SAT;
    else if (issue)           elapsed <= EW'(1);
    else if (elapsed != SAT)  elapsed <= elapsed + EW'(1);
  end

  // Cycles since the last inserted no-op, saturating.
  always_ff @(posedge clk) begin
    if (!rst_n)                 since_nop <= SAT;
    else if (idle_ins)          since_nop <= EW'(1);
    else if (since_nop != SAT)  since_nop <= since_nop + EW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        nop_done <= 1'b0;
    else if (issue)    nop_done <= 1'b0;
    else if (idle_ins) nop_done <= 1'b1;
  end

endmodule

// File: rtl/col_spacing_sched.sv
module col_spacing_sched
  import colsp_pkg::*;
#(
  parameter int TW    = 6,
  parameter int DEV_W = 2,
  localparam int EW   = TW + 2,
  localparam int NDEV = 1 << DEV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    t_cc,
  input  logic [TW-1:0]    t_cac,
  input  logic [TW-1:0]    t_cwd,
  input  logic [TW-1:0]    t_rtr,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [DEV_W-1:0] cmd_dev,
  output logic             issue,
  output logic             idle_ins
);

  cls_e             c_cls, a_cls, b_cls;
  logic [DEV_W-1:0] a_dev, b_dev;
  logic             a_dirty, hazard, nop_done;
  logic [EW-1:0]    need, elapsed, since_nop;
  logic [NDEV-1:0]  wbuf_dirty;

  assign c_cls = colsp_classify(cmd_op);

  colsp_hist #(.DEV_W(DEV_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (issue),
    .push_cls   (c_cls),
    .push_dev   (cmd_dev),
    .retire_all (idle_ins),
    .a_cls      (a_cls),
    .a_dev      (a_dev),
    .a_dirty    (a_dirty),
    .b_cls      (b_cls),
    .b_dev      (b_dev),
    .dirty_vec  (wbuf_dirty)
  );

  colsp_rule #(.DEV_W(DEV_W), .TW(TW)) u_rule (
    .c_cls   (c_cls),
    .c_dev   (cmd_dev),
    .a_cls   (a_cls),
    .a_dev   (a_dev),
    .a_dirty (a_dirty),
    .b_cls   (b_cls),
    .b_dev   (b_dev),
    .t_cc    (t_cc),
    .t_cac   (t_cac),
    .t_cwd   (t_cwd),
    .hazard  (hazard),
    .need    (need)
  );

  colsp_pace #(.TW(TW)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .idle_ins  (idle_ins),
    .elapsed   (elapsed),
    .since_nop (since_nop),
    .nop_done  (nop_done)
  );

  always_comb begin
    if (hazard)
      cmd_ready = nop_done && (elapsed >= EW'(t_rtr)) && (since_nop >= EW'(t_cc));
    else
      cmd_ready = (elapsed >= need);
    idle_ins = cmd_valid && hazard && !nop_done && (elapsed >= EW'(t_cc));
    issue    = cmd_valid && cmd_ready;
  end

endmodule

// File: rtl/colsp_chk.sv
module colsp_chk
  import colsp_pkg::*;
#(
  parameter int TW    = 6,
  parameter int DEV_W = 2,
  localparam int EW   = TW + 2,
  localparam int NDEV = 1 << DEV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TW-1:0]    t_cc,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [DEV_W-1:0] cmd_dev,
  input logic             issue,
  input logic             idle_ins,
  input logic [NDEV-1:0]  wbuf_dirty
);

  logic [EW-1:0]    gap;
  logic [DEV_W-1:0] prev_dev;
  logic             first_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap <= '1;
    else if (issue || idle_ins)   gap <= EW'(1);
    else if (gap != '1)           gap <= gap + EW'(1);
  end

  always_ff @(posedge clk) begin
    prev_dev  <= cmd_dev;
    first_cyc <= !rst_n;
  end

  p_min_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || idle_ins) |-> (gap >= EW'(t_cc)));

  p_single_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && idle_ins));

  p_idle_needs_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ins |-> cmd_valid);

  p_wr_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && colsp_classify(cmd_op) == CLS_WR) |=> wbuf_dirty[prev_dev]);

  p_idle_retires_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ins |=> (wbuf_dirty == '0));

  p_ready_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    first_cyc |-> cmd_ready);

endmodule

bind col_spacing_sched colsp_chk #(.TW(TW), .DEV_W(DEV_W)) u_colsp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .t_cc       (t_cc),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_dev    (cmd_dev),
  .issue      (issue),
  .idle_ins   (idle_ins),
  .wbuf_dirty (wbuf_dirty)
);

// File: tb/tb_col_spacing_sched.sv
`timescale 1ns/1ps
module tb_col_spacing_sched;

  localparam int TW = 6;
  localparam int DEV_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] t_cc, t_cac, t_cwd, t_rtr;
  logic cmd_valid = 1'b0, cmd_ready, issue, idle_ins;
  logic [2:0] cmd_op = 3'd0;
  logic [DEV_W-1:0] cmd_dev = '0;

  col_spacing_sched #(.TW(TW), .DEV_W(DEV_W)) dut (
    .clk(clk), .rst_n(rst_n), .t_cc(t_cc), .t_cac(t_cac), .t_cwd(t_cwd),
    .t_rtr(t_rtr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .issue(issue), .idle_ins(idle_ins));

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0, n_cmp = 0, n_bad = 0;
  int last_idle = -1;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: class 0 nop, 1 read, 2 write.
  int ha_c = 0, ha_d = 0, ha_x = 0, hb_c = 0, hb_d = 0, hb_x = 0;
  int last_real = -100000, nop_cyc = -100000;
  bit nop_done = 0;
  bit ur[4] = '{default: 0};

  function automatic int cls_of(input int op);
    if (op == 1 || op == 5) return 1;
    if (op == 2 || op == 6) return 2;
    return 0;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int c, el, need;
      bit hz, er, ei;
      c  = cls_of(int'(cmd_op));
      el = cyc - last_real;
      hz = (c == 1) && (hb_c == 2) && (hb_d == int'(cmd_dev)) && (ha_d == hb_d) &&
           (ha_c == 2 || (ha_c == 1 && ha_x == 1));
      if (hz) begin
        er = nop_done && (el >= int'(t_rtr)) && (cyc - nop_cyc >= int'(t_cc));
        ei = cmd_valid && !nop_done && (el >= int'(t_cc));
      end else begin
        need = int'(t_cc);
        if (hb_c == 1 && c == 2 && t_cac > t_cwd) need += int'(t_cac) - int'(t_cwd);
        er = (el >= need);
        ei = 0;
      end
      chk("R10 ready", int'(cmd_ready), int'(er));
      chk("R4 idle_ins", int'(idle_ins), int'(ei));
      chk("R10 issue", int'(issue), int'(cmd_valid && er));
      if (idle_ins) last_idle = cyc;
      if (ei) begin
        nop_done = 1; nop_cyc = cyc;
        foreach (ur[i]) ur[i] = 0;
      end
      if (cmd_valid && er) begin
        ha_c = hb_c; ha_d = hb_d; ha_x = hb_x;
        hb_c = c; hb_d = int'(cmd_dev); hb_x = int'(ur[cmd_dev]);
        ur[cmd_dev] = (c == 2);
        last_real = cyc; nop_done = 0;
      end
    end
  end

  // Offer a command at a falling edge, return the cycle it issues in.
  task automatic send(input int op, input int dev, output int at);
    cmd_op = 3'(op); cmd_dev = DEV_W'(dev); cmd_valid = 1'b1;
    forever begin
      #1;
      if (cmd_ready) begin at = cyc; break; end
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic sep();
    int t;
    send(0, 3, t); send(0, 3, t);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3, li;
    t_cc = 4; t_cac = 8; t_cwd = 6; t_rtr = 12;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 ready after reset", int'(cmd_ready), 1);
    @(negedge clk);
    send(1, 0, t0); chk("R8 first issue at once", t0, cyc - 1);
    send(1, 0, t1); chk("R3 rd-rd", t1 - t0, 4);
    send(2, 0, t2); chk("R2 rd-wr", t2 - t1, 6);
    send(2, 1, t3); chk("R3 wr-wr", t3 - t2, 4);
    send(0, 0, t0); chk("R3 wr-nop", t0 - t3, 4);
    send(1, 1, t1); chk("R3 nop-rd", t1 - t0, 4);
    // write, write, read on one device
    send(2, 2, t2); chk("R2 rd-wr other device", t2 - t1, 6);
    send(2, 2, t3); chk("R3 wr-wr", t3 - t2, 4);
    send(1, 2, t0); chk("R4 wr-wr-rd gap", t0 - t3, 12);
    chk("R4 inserted no-op position", last_idle - t3, 4);
    chk("R1 no-op to read", t0 - last_idle, 8);
    li = last_idle;
    // read on another device
    send(2, 3, t1); send(2, 3, t2); send(1, 1, t3);
    chk("R5 read other device", t3 - t2, 4);
    chk("R5 no inserted no-op", last_idle, li);
    // oldest write on another device
    send(2, 1, t1); send(2, 3, t2); send(1, 3, t3);
    chk("R5 oldest write other device", t3 - t2, 4);
    chk("R5 no inserted no-op", last_idle, li);
    // precharge-only acts as no-op
    send(3, 0, t1); send(2, 0, t2); send(1, 0, t3);
    chk("R7 precharge-only as no-op", t3 - t2, 4);
    // read-write-read with unretired earlier write
    sep();
    send(2, 0, t0); send(1, 0, t1);
    send(2, 0, t2); chk("R2 rd-wr", t2 - t1, 6);
    send(1, 0, t3); chk("R6 rd-wr-rd unretired", t3 - t2, 12);
    chk("R9 retire no-op inserted", last_idle - t2, 4);
    li = last_idle;
    // read-write-read with nothing unretired
    sep();
    send(1, 0, t1); send(2, 0, t2); send(1, 0, t3);
    chk("R6 rd-wr-rd retired", t3 - t2, 4);
    chk("R9 no no-op when retired", last_idle, li);
    // auto-precharge encodings
    send(5, 1, t1); send(6, 1, t2); chk("R7 rda-wra", t2 - t1, 6);
    sep();
    send(6, 1, t1); send(2, 1, t2); send(5, 1, t3);
    chk("R7 wra-wr-rda hazard", t3 - t2, 12);
    sep();
    send(2, 0, t1); send(4, 0, t2); send(1, 0, t3);
    chk("R7 code 4 as no-op", t3 - t2, 4);
    // short retire time: no-op spacing dominates
    t_rtr = 5;
    sep();
    send(2, 2, t1); send(2, 2, t2); send(1, 2, t3);
    chk("R4 short t_rtr gap", t3 - t2, 8);
    chk("R1 no-op to read short", t3 - last_idle, 4);
    // read latency below write latency
    t_cac = 3;
    sep();
    send(1, 1, t1); send(2, 1, t2);
    chk("R2 clamp to t_cc", t2 - t1, 4);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule